// File: doc/BRIEF.md
# Bulk Translation Entry Update Sequencer

This block applies one multi-page update to an address translation table. A command names a table, a bus address, a page count and a mode. In fill mode every targeted page receives the same entry value. In list mode the entries come from a list in system memory, one 64-bit word per page. The block fetches each word and writes it to the table.

The block checks the command before it touches anything. It then walks the bus address one page at a time, starting from the address aligned down to the table's page size. For each page it presents one write on the table's single-entry port. It ends when every page is written or when the table rejects an address. It then returns a status and the index of the last entry that was stored. It owns neither the table storage nor the lookup path. It only sequences writes into them.

Top module: `xlat_bulk_updater`

## Requirements
- R1: A command whose table identifier differs from `cfg_table_id` completes with status 1 (parameter error) and index 0. It causes no table write and no memory request.
- R2: A command with a page count of zero, in either mode, completes with status 1, index 0 and no table write.
- R3: In list mode a page count above 512 completes with status 1 and no write or fetch. A count of exactly 512 is accepted.
- R4: In list mode a list base address with any of its low 12 bits set completes with status 1 and no write or fetch.
- R5: In fill mode a page count above `cfg_table_entries` completes with status 1 and no write.
- R6: In fill mode the first write targets `cmd_bus_addr` with its low `cfg_page_shift` bits cleared. Each further write targets the previous address plus 2^`cfg_page_shift`. Every write carries `cmd_fill_value`. No memory request is made.
- R7: In list mode entry i is read from `cmd_list_base + 8*i`. The returned word is big-endian: `mem_rsp_data[7:0]` is the byte at the lowest address and becomes bits [63:56] of the written entry. The written entry is the byte-reversed response.
- R8: When the table answers a write with `tbl_wr_reject` high, the block makes no further write or fetch and completes with status 1. Entries already written stay in place.
- R9: The reported index is the number of entries the table accepted minus one, or 0 when none was accepted. A command whose pages are all accepted completes with status 0 and index N-1.
- R10: `busy` rises the cycle after a command is accepted and stays high through the single-cycle `done_valid` pulse. `cmd_valid` is ignored while `busy` is high.
- R11: A table write holds `tbl_wr_valid`, address and data steady until `tbl_wr_resp`. A memory request holds `mem_req_valid` and its address steady until `mem_req_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command offered (taken when not busy) |
| cmd_list_mode | input | 1 | 1 = list mode, 0 = fill mode |
| cmd_table_id | input | ID_W | Table identifier named by the command |
| cmd_bus_addr | input | ADDR_W | Bus address of the first page |
| cmd_list_base | input | ADDR_W | Memory address of the entry list |
| cmd_fill_value | input | ENT_W | Entry value for fill mode |
| cmd_pages | input | CNT_W | Number of pages to update |
| cfg_table_id | input | ID_W | Identifier of the attached table |
| cfg_page_shift | input | SHIFT_W | log2 of the table page size |
| cfg_table_entries | input | CNT_W | Number of entries in the table |
| busy | output | 1 | Command in progress |
| mem_req_valid | output | 1 | List word read request |
| mem_req_addr | output | ADDR_W | Address of the list word |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | ENT_W | Read data, lowest address in bits [7:0] |
| tbl_wr_valid | output | 1 | Table entry write request |
| tbl_wr_addr | output | ADDR_W | Bus address being mapped |
| tbl_wr_data | output | ENT_W | Entry value to store |
| tbl_wr_resp | input | 1 | Table has answered the write |
| tbl_wr_reject | input | 1 | With tbl_wr_resp: address out of range |
| done_valid | output | 1 | One-cycle completion pulse |
| done_status | output | 2 | 0 = success, 1 = parameter error |
| done_index | output | CNT_W | Last accepted entry index, clamped to 0 |

## Verification
The assertions assume three things. The configuration inputs hold still while `busy` is high. The table raises `tbl_wr_resp` only for a pending write, for a single cycle. The memory returns exactly one response for each accepted request, no earlier than the cycle after acceptance. The bench models the table and the memory as registered responders that answer one cycle after they see a request. Its memory ready line toggles every cycle, so requests are also held across refusals. Configuration changes only between commands, once `done_valid` has been seen.

// File: rtl/xbu_pkg.sv
package xbu_pkg;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_CHECK     = 3'd1,
        ST_FETCH     = 3'd2,
        ST_WAIT_DATA = 3'd3,
        ST_WRITE     = 3'd4,
        ST_DONE      = 3'd5
    } seq_state_e;

    typedef enum logic [1:0] {
        STS_OK    = 2'd0,
        STS_PARAM = 2'd1
    } seq_status_e;

endpackage

// File: rtl/xbu_cmd_check.sv
module xbu_cmd_check #(
    parameter int ID_W             = 8,
    parameter int ADDR_W           = 32,
    parameter int CNT_W            = 16,
    parameter int LIST_MAX         = 512,
    parameter int LIST_ALIGN_SHIFT = 12
) (
    input  logic              list_mode,
    input  logic [ID_W-1:0]   tid,
    input  logic [ID_W-1:0]   cfg_tid,
    input  logic [CNT_W-1:0]  pages,
    input  logic [ADDR_W-1:0] lbase,
    input  logic [CNT_W-1:0]  table_entries,
    output logic              bad
);
    localparam logic [CNT_W-1:0] LIST_CAP = CNT_W'(LIST_MAX);

    always_comb begin
        bad = 1'b0;
        if (tid != cfg_tid) begin
            bad = 1'b1;
        end else if (pages == '0) begin
            bad = 1'b1;
        end else if (list_mode) begin
            if (pages > LIST_CAP || lbase[LIST_ALIGN_SHIFT-1:0] != '0) begin
                bad = 1'b1;
            end
        end else if (pages > table_entries) begin
            bad = 1'b1;
        end
    end
endmodule

// File: rtl/xbu_page_step.sv
module xbu_page_step #(
    parameter int ADDR_W  = 32,
    parameter int SHIFT_W = 5
) (
    input  logic [SHIFT_W-1:0] shift,
    input  logic [ADDR_W-1:0]  addr,
    output logic [ADDR_W-1:0]  page_size,
    output logic [ADDR_W-1:0]  aligned
);
    always_comb begin
        page_size = ADDR_W'(1) << shift;
        aligned   = addr & ~(page_size - ADDR_W'(1));
    end
endmodule

// File: rtl/xbu_be_swap.sv
module xbu_be_swap #(
    parameter int ENT_W = 64
) (
    input  logic [ENT_W-1:0] raw,
    output logic [ENT_W-1:0] entry
);
    localparam int NBYTES = ENT_W / 8;

    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        assign entry[8*b +: 8] = raw[8*(NBYTES-1-b) +: 8];
    end
endmodule

// File: rtl/xlat_bulk_updater.sv
module xlat_bulk_updater
    import xbu_pkg::*;
#(
    parameter int ID_W             = 8,
    parameter int ADDR_W           = 32,
    parameter int ENT_W            = 64,
    parameter int CNT_W            = 16,
    parameter int SHIFT_W          = 5,
    parameter int LIST_MAX         = 512,
    parameter int LIST_ALIGN_SHIFT = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    input  logic               cmd_list_mode,
    input  logic [ID_W-1:0]    cmd_table_id,
    input  logic [ADDR_W-1:0]  cmd_bus_addr,
    input  logic [ADDR_W-1:0]  cmd_list_base,
    input  logic [ENT_W-1:0]   cmd_fill_value,
    input  logic [CNT_W-1:0]   cmd_pages,
    input  logic [ID_W-1:0]    cfg_table_id,
    input  logic [SHIFT_W-1:0] cfg_page_shift,
    input  logic [CNT_W-1:0]   cfg_table_entries,
    output logic               busy,
    output logic               mem_req_valid,
    output logic [ADDR_W-1:0]  mem_req_addr,
    input  logic               mem_req_ready,
    input  logic               mem_rsp_valid,
    input  logic [ENT_W-1:0]   mem_rsp_data,
    output logic               tbl_wr_valid,
    output logic [ADDR_W-1:0]  tbl_wr_addr,
    output logic [ENT_W-1:0]   tbl_wr_data,
    input  logic               tbl_wr_resp,
    input  logic               tbl_wr_reject,
    output logic               done_valid,
    output logic [1:0]         done_status,
    output logic [CNT_W-1:0]   done_index
);
    localparam int STRIDE_SHIFT = $clog2(ENT_W / 8);

    typedef struct packed {
        seq_state_e           st;
        logic                 list_mode;
        logic [ID_W-1:0]      tid;
        logic [ADDR_W-1:0]    addr;
        logic [ADDR_W-1:0]    lbase;
        logic [ENT_W-1:0]     ent;
        logic [CNT_W-1:0]     total;
        logic [CNT_W-1:0]     ok_cnt;
        seq_status_e          sts;
    } seq_regs_t;

    seq_regs_t q, d;

    logic              cmd_bad;
    logic [ADDR_W-1:0] page_size;
    logic [ADDR_W-1:0] aligned_addr;
    logic [ENT_W-1:0]  fetched_entry;
    logic [CNT_W-1:0]  ok_next;

    xbu_cmd_check #(
        .ID_W(ID_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W),
        .LIST_MAX(LIST_MAX), .LIST_ALIGN_SHIFT(LIST_ALIGN_SHIFT)
    ) u_check (
        .list_mode     (q.list_mode),
        .tid           (q.tid),
        .cfg_tid       (cfg_table_id),
        .pages         (q.total),
        .lbase         (q.lbase),
        .table_entries (cfg_table_entries),
        .bad           (cmd_bad)
    );

    xbu_page_step #(.ADDR_W(ADDR_W), .SHIFT_W(SHIFT_W)) u_step (
        .shift     (cfg_page_shift),
        .addr      (q.addr),
        .page_size (page_size),
        .aligned   (aligned_addr)
    );

    xbu_be_swap #(.ENT_W(ENT_W)) u_swap (
        .raw   (mem_rsp_data),
        .entry (fetched_entry)
    );

    assign ok_next = q.ok_cnt + CNT_W'(1);

    always_comb begin
        d = q;
        unique case (q.st)
            ST_IDLE: begin
                if (cmd_valid) begin
                    d.st        = ST_CHECK;
                    d.list_mode = cmd_list_mode;
                    d.tid       = cmd_table_id;
                    d.addr      = cmd_bus_addr;
                    d.lbase     = cmd_list_base;
                    d.ent       = cmd_fill_value;
                    d.total     = cmd_pages;
                    d.ok_cnt    = '0;
                    d.sts       = STS_OK;
                end
            end
            ST_CHECK: begin
                if (cmd_bad) begin
                    d.st  = ST_DONE;
                    d.sts = STS_PARAM;
                end else begin
                    d.addr = aligned_addr;
                    d.st   = q.list_mode ? ST_FETCH : ST_WRITE;
                end
            end
            ST_FETCH: begin
                if (mem_req_ready) begin
                    d.st = ST_WAIT_DATA;
                end
            end
            ST_WAIT_DATA: begin
                if (mem_rsp_valid) begin
                    d.ent = fetched_entry;
                    d.st  = ST_WRITE;
                end
            end
            ST_WRITE: begin
                if (tbl_wr_resp) begin
                    if (tbl_wr_reject) begin
                        d.st  = ST_DONE;
                        d.sts = STS_PARAM;
                    end else begin
                        d.ok_cnt = ok_next;
                        d.addr   = q.addr + page_size;
                        if (ok_next == q.total) begin
                            d.st  = ST_DONE;
                            d.sts = STS_OK;
                        end else begin
                            d.st = q.list_mode ? ST_FETCH : ST_WRITE;
                        end
                    end
                end
            end
            ST_DONE: begin
                d.st = ST_IDLE;
            end
            default: begin
                d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, sts: STS_OK, default: '0};
        end else begin
            q <= d;
        end
    end

    assign busy          = (q.st != ST_IDLE);
    assign mem_req_valid = (q.st == ST_FETCH);
    assign mem_req_addr  = q.lbase + (ADDR_W'(q.ok_cnt) << STRIDE_SHIFT);
    assign tbl_wr_valid  = (q.st == ST_WRITE);
    assign tbl_wr_addr   = q.addr;
    assign tbl_wr_data   = q.ent;
    assign done_valid    = (q.st == ST_DONE);
    assign done_status   = q.sts;
    assign done_index    = (q.ok_cnt == '0) ? '0 : q.ok_cnt - CNT_W'(1);

    // R1: a foreign table identifier ends the command with a parameter error
    p_foreign_id_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_CHECK && q.tid != cfg_table_id)
        |=> (done_valid && done_status == STS_PARAM));

    // R3: list fetches never go past the list capacity
    p_list_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (q.ok_cnt < CNT_W'(LIST_MAX)));

    // R4: misaligned list base is refused right after the check
    p_misalign_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_CHECK && q.list_mode && q.tid == cfg_table_id
         && q.lbase[LIST_ALIGN_SHIFT-1:0] != '0)
        |=> (done_valid && done_status == STS_PARAM));

    // R5: fill count beyond the table size is refused
    p_fill_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_CHECK && !q.list_mode && q.total > cfg_table_entries)
        |=> (done_valid && done_status == STS_PARAM));

    // R6: fill mode never reads memory
    p_fill_nofetch_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !q.list_mode) |-> !mem_req_valid);

    // R8: after a rejected write the sequence ends at once
    p_stop_on_reject_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tbl_wr_valid && tbl_wr_resp && tbl_wr_reject)
        |=> (!tbl_wr_valid && !mem_req_valid && done_valid && done_status == STS_PARAM));

    // R9: success is only reported once every page was accepted
    p_full_success_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && done_status == STS_OK) |-> (q.ok_cnt == q.total && q.total != '0));

    // R10: completion is a single-cycle pulse inside the busy window
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> (!done_valid && !busy));
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!tbl_wr_valid && !mem_req_valid && !done_valid));

    // R11: pending requests hold steady
    p_wr_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (tbl_wr_valid && !tbl_wr_resp)
        |=> (tbl_wr_valid && $stable(tbl_wr_addr) && $stable(tbl_wr_data)));
    p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready)
        |=> (mem_req_valid && $stable(mem_req_addr)));

endmodule

// File: tb/sim_xlat_bulk_updater.sv
module sim_xlat_bulk_updater;
    localparam int ID_W = 8, ADDR_W = 32, ENT_W = 64, CNT_W = 16, SHIFT_W = 5;
    localparam int TBL_DEPTH = 1024;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic               cmd_valid = 1'b0;
    logic               cmd_list_mode = 1'b0;
    logic [ID_W-1:0]    cmd_table_id = '0;
    logic [ADDR_W-1:0]  cmd_bus_addr = '0;
    logic [ADDR_W-1:0]  cmd_list_base = '0;
    logic [ENT_W-1:0]   cmd_fill_value = '0;
    logic [CNT_W-1:0]   cmd_pages = '0;
    logic [ID_W-1:0]    cfg_table_id = 8'h5A;
    logic [SHIFT_W-1:0] cfg_page_shift = 5'd12;
    logic [CNT_W-1:0]   cfg_table_entries = 16'd16;
    logic               busy;
    logic               mem_req_valid;
    logic [ADDR_W-1:0]  mem_req_addr;
    logic               mem_req_ready;
    logic               mem_rsp_valid;
    logic [ENT_W-1:0]   mem_rsp_data;
    logic               tbl_wr_valid;
    logic [ADDR_W-1:0]  tbl_wr_addr;
    logic [ENT_W-1:0]   tbl_wr_data;
    logic               tbl_wr_resp;
    logic               tbl_wr_reject;
    logic               done_valid;
    logic [1:0]         done_status;
    logic [CNT_W-1:0]   done_index;

    xlat_bulk_updater u0 (.*);

    int n_cmp = 0, n_bad = 0;
    int tb_limit = 16;
    logic [ENT_W-1:0] tbl_mem [TBL_DEPTH];
    int wr_total = 0, fetch_total = 0, done_total = 0;
    logic [1:0] last_sts;
    logic [CNT_W-1:0] last_idx;
    logic resp_q = 1'b0, rej_q = 1'b0, rdy_q = 1'b0, rsp_q = 1'b0;
    logic [ENT_W-1:0] rsp_d = '0;

    function automatic logic [ENT_W-1:0] raw_of(input logic [ADDR_W-1:0] a);
        return {a ^ 32'hC3A5_0F00, a + 32'h0101_0033};
    endfunction

    function automatic logic [ENT_W-1:0] bswap(input logic [ENT_W-1:0] v);
        logic [ENT_W-1:0] r;
        for (int b = 0; b < 8; b++) r[8*b +: 8] = v[8*(7-b) +: 8];
        return r;
    endfunction

    // table model: answers one cycle after it sees a write
    assign tbl_wr_resp   = resp_q;
    assign tbl_wr_reject = rej_q;
    always @(posedge clk) begin
        if (tbl_wr_valid && !resp_q) begin
            int idx;
            idx = int'(tbl_wr_addr >> cfg_page_shift);
            resp_q <= 1'b1;
            rej_q  <= (idx >= tb_limit);
            if (idx < tb_limit) begin
                wr_total <= wr_total + 1;
                if (idx < TBL_DEPTH) tbl_mem[idx] <= tbl_wr_data;
            end
        end else begin
            resp_q <= 1'b0;
            rej_q  <= 1'b0;
        end
    end

    // memory model: ready toggles, data one cycle after acceptance
    assign mem_req_ready = rdy_q;
    assign mem_rsp_valid = rsp_q;
    assign mem_rsp_data  = rsp_d;
    always @(posedge clk) begin
        rdy_q <= ~rdy_q;
        if (mem_req_valid && rdy_q) begin
            rsp_q <= 1'b1;
            rsp_d <= raw_of(mem_req_addr);
            fetch_total <= fetch_total + 1;
        end else begin
            rsp_q <= 1'b0;
        end
    end

    always @(posedge clk) begin
        if (done_valid) begin
            done_total <= done_total + 1;
            last_sts   <= done_status;
            last_idx   <= done_index;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    int r_wr, r_fetch;

    task automatic run_cmd(input logic mode, input logic [ID_W-1:0] id, input logic [ADDR_W-1:0] addr,
                           input logic [ADDR_W-1:0] base, input logic [ENT_W-1:0] val, input int pages);
        int w0, f0, d0, t;
        @(negedge clk);
        w0 = wr_total; f0 = fetch_total; d0 = done_total;
        cmd_valid = 1'b1; cmd_list_mode = mode; cmd_table_id = id;
        cmd_bus_addr = addr; cmd_list_base = base; cmd_fill_value = val;
        cmd_pages = CNT_W'(pages);
        @(negedge clk);
        cmd_valid = 1'b0;
        t = 0;
        while (done_total == d0 && t < 5000) begin
            @(negedge clk);
            t++;
        end
        @(negedge clk);
        r_wr = wr_total - w0;
        r_fetch = fetch_total - f0;
    endtask

    task automatic expect_param(input string req);
        chk(last_sts == 2'd1, req, last_sts, 1);
        chk(last_idx == 0, req, last_idx, 0);
        chk(r_wr == 0, req, r_wr, 0);
        chk(r_fetch == 0, req, r_fetch, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [ENT_W-1:0] val;
        int k, exp_idx, start;
        repeat (3) @(negedge clk);
        chk(busy == 0 && done_valid == 0, "reset R10", {busy, done_valid}, 0);
        chk(tbl_wr_valid == 0 && mem_req_valid == 0, "reset R11", {tbl_wr_valid, mem_req_valid}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // fill sweep: two page sizes, start pages across the table edge
        for (int sh = 12; sh <= 14; sh += 2) begin
            cfg_page_shift = SHIFT_W'(sh);
            for (int st = 0; st < 18; st++) begin
                for (int n = 1; n <= 5; n++) begin
                    val = {16'hF111, 16'(sh), 16'(st), 16'(n)};
                    run_cmd(1'b0, 8'h5A, (32'(st) << sh) | 32'((st * 37 + 5) % (1 << sh)), 32'h0, val, n);
                    k = (st >= 16) ? 0 : ((16 - st) < n ? (16 - st) : n);
                    exp_idx = (k == 0) ? 0 : k - 1;
                    chk(r_wr == k, "R6 write count", r_wr, k);
                    chk(r_fetch == 0, "R6 no fetch", r_fetch, 0);
                    chk(last_idx == CNT_W'(exp_idx), "R9 index", last_idx, exp_idx);
                    chk(last_sts == ((k == n) ? 2'd0 : 2'd1), "R8 status", last_sts, (k == n) ? 0 : 1);
                    for (int i = 0; i < k; i++)
                        chk(tbl_mem[st + i] == val, "R6 entry", tbl_mem[st + i], val);
                end
            end
        end
        cfg_page_shift = 5'd12;

        // fill boundaries
        run_cmd(1'b0, 8'h5A, 32'h0, 32'h0, 64'h77, 17);
        expect_param("R5 count over table");
        run_cmd(1'b0, 8'h5A, 32'h0, 32'h0, 64'h78, 16);
        chk(last_sts == 0 && last_idx == 15 && r_wr == 16, "R9 full table", {last_sts, last_idx}, 15);
        run_cmd(1'b0, 8'h5A, 32'h0, 32'h0, 64'h79, 0);
        expect_param("R2 zero fill");
        run_cmd(1'b1, 8'h5A, 32'h0, 32'h3000, 64'h0, 0);
        expect_param("R2 zero list");
        run_cmd(1'b0, 8'h5B, 32'h0, 32'h0, 64'h7A, 3);
        expect_param("R1 id mismatch fill");
        run_cmd(1'b1, 8'h00, 32'h0, 32'h3000, 64'h0, 3);
        expect_param("R1 id mismatch list");

        // list sweep
        for (int st = 0; st < 18; st++) begin
            for (int n = 1; n <= 4; n++) begin
                logic [ADDR_W-1:0] base;
                base = 32'((st * 5 + n) * 4096);
                run_cmd(1'b1, 8'h5A, (32'(st) << 12) | 32'h2C, base, 64'h0, n);
                k = (st >= 16) ? 0 : ((16 - st) < n ? (16 - st) : n);
                exp_idx = (k == 0) ? 0 : k - 1;
                chk(r_wr == k, "R7 write count", r_wr, k);
                chk(r_fetch == ((k < n) ? k + 1 : n), "R8 fetch count", r_fetch, (k < n) ? k + 1 : n);
                chk(last_idx == CNT_W'(exp_idx), "R9 list index", last_idx, exp_idx);
                chk(last_sts == ((k == n) ? 2'd0 : 2'd1), "R8 list status", last_sts, (k == n) ? 0 : 1);
                for (int i = 0; i < k; i++)
                    chk(tbl_mem[st + i] == bswap(raw_of(base + 32'(8 * i))), "R7 entry",
                        tbl_mem[st + i], bswap(raw_of(base + 32'(8 * i))));
            end
        end

        // list alignment and size limits
        run_cmd(1'b1, 8'h5A, 32'h0, 32'h4008, 64'h0, 2);
        expect_param("R4 base off by 8");
        run_cmd(1'b1, 8'h5A, 32'h0, 32'h4800, 64'h0, 2);
        expect_param("R4 base off by 0x800");
        tb_limit = 600;
        run_cmd(1'b1, 8'h5A, 32'h0, 32'h10000, 64'h0, 513);
        expect_param("R3 list 513");
        run_cmd(1'b1, 8'h5A, 32'h0, 32'h10000, 64'h0, 512);
        chk(last_sts == 0, "R3 list 512 status", last_sts, 0);
        chk(last_idx == 511, "R9 list 512 index", last_idx, 511);
        chk(r_wr == 512 && r_fetch == 512, "R3 list 512 traffic", r_wr, 512);
        chk(tbl_mem[511] == bswap(raw_of(32'h10000 + 32'(8 * 511))), "R7 last entry",
            tbl_mem[511], bswap(raw_of(32'h10000 + 32'(8 * 511))));
        tb_limit = 16;

        // command offered while busy is ignored
        start = done_total;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_list_mode = 1'b0; cmd_table_id = 8'h5A;
        cmd_bus_addr = 32'h2000; cmd_fill_value = 64'hAAAA; cmd_pages = 16'd4;
        @(negedge clk);
        chk(busy == 1, "R10 busy after accept", busy, 1);
        cmd_fill_value = 64'hBBBB; cmd_bus_addr = 32'h9000; cmd_pages = 16'd1;
        repeat (3) @(negedge clk);
        cmd_valid = 1'b0;
        repeat (40) @(negedge clk);
        chk(done_total - start == 1, "R10 one completion", done_total - start, 1);
        chk(tbl_mem[9] != 64'hBBBB, "R10 ignored cmd", tbl_mem[9], 0);
        chk(tbl_mem[5] == 64'hAAAA && busy == 0, "R10 first cmd done", tbl_mem[5], 64'hAAAA);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule